// File: doc/BRIEF.md
# Frame Start Sequencer with Header-Selected Pixel Depth

This block runs the per-frame control of a frame-buffer display controller. On each frame request it fetches the first word of the current frame buffer, which is the leading palette entry. It decodes the pixel depth from a field of that word and works out where the pixel data begins. It then checks that the whole frame fits between the buffer's top and bottom addresses. When the frame fits, it hands the pixel fetcher a base address, a pixel format, a byte stride, a first line and a line count, using a one-cycle start strobe. The fetcher later returns a done strobe.

Two frame buffers can be used in turn (dual mode). A subpanel control word can move the first displayed line or shorten the number of lines fetched. When a frame overruns its buffer, the block raises a sticky sync error and stops. When a buffer address is unusable at enable time, it reports a fault condition and stays stopped. Per-buffer completion conditions and a DMA interrupt strobe are given as one-cycle pulses.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset, `fetch_start`, `hdr_req`, `sync_err`, `cond_pulse`, `dma_irq` and `pal_loaded` are all 0 and `active_buf` is 0.
- R2: `frame_req` starts a frame only while `enable` is high, the block has not stopped itself, and `pal_mode` is not 1. In mode 1 a request causes neither a header read nor a fetch start.
- R3: When `pal_mode` is not 2, each frame raises `hdr_req` with `hdr_addr` equal to the top address of the active buffer. `pal_loaded` pulses for the first header taken after each rising edge of `enable`, and only then. In mode 2 no header is read, the depth comes from the last header taken, and the data offset is 0.
- R4: The depth code is `hdr_word[14:12]`. Code 1 gives 2 bpp (format 0), code 2 gives 4 bpp (format 1) and code 3 gives 8 bpp (format 2). Codes 4 to 7 give 16 bpp: format 3 (12-bit passive) when `tft` is 0, and format 4 (16-bit active) when `tft` is 1. Code 0 drops the frame with no start and no error.
- R5: With a header present, the data offset is 0x200 bytes for codes 3 to 7 and 0x20 for codes 1 and 2. `fetch_base` is the buffer top plus the offset, and `fetch_stride` is width × bpp / 8.
- R6: If offset + width × height × bpp / 8 is greater than (bottom − top) + 2, the block sets `sync_err`, issues no start, and ignores later requests. A need exactly equal to that limit is accepted.
- R7: `sync_err` clears while `enable` is low. A rising edge of `enable` sets `active_buf` to 0.
- R8: A successful start pulses `cond_pulse[N]` for active buffer N for one cycle, together with `fetch_start`. `dma_irq` pulses in the same cycle when `dma_mask[0]` is 1.
- R9: In dual mode `active_buf` flips after each start. Without dual mode it holds.
- R10: On a rising edge of `enable`, the block checks `top_ok[0]` and `bot_ok[0]`, and also `top_ok[1]` and `bot_ok[1]` when `dual` is set. If any checked flag is low, `cond_pulse[2]` pulses one cycle later, `dma_irq` pulses with it when `dma_mask[1]` is 1, and no frame runs until the next rising edge of `enable`.
- R11: When `subpanel[31]` is 1 and `subpanel[29]` is 1, `fetch_first` is `subpanel[25:16]` and `fetch_lines` is `height`. When `subpanel[31]` is 1 and `subpanel[29]` is 0, `fetch_first` is 0 and `fetch_lines` is `subpanel[25:16]`. Otherwise `fetch_first` is 0 and `fetch_lines` is `height`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable level |
| pal_mode | input | 2 | Palette mode: 0/3 header every frame, 1 no frames, 2 no header |
| tft | input | 1 | Selects the 16-bit active format at 16 bpp |
| dual | input | 1 | Alternate between two buffers |
| dma_mask | input | 2 | Bit 0 frame-start interrupt enable, bit 1 address-fault enable |
| width | input | DIM_W | Pixels per line |
| height | input | DIM_W | Lines per frame |
| subpanel | input | SUB_W | Subpanel control word |
| buf0_top | input | AW | Buffer 0 first byte address |
| buf0_bot | input | AW | Buffer 0 end address |
| buf1_top | input | AW | Buffer 1 first byte address |
| buf1_bot | input | AW | Buffer 1 end address |
| top_ok | input | 2 | Top address usable, per buffer |
| bot_ok | input | 2 | Bottom address usable, per buffer |
| frame_req | input | 1 | Frame start request |
| hdr_req | output | 1 | Header word read request |
| hdr_addr | output | AW | Header read address |
| hdr_ack | input | 1 | Header word valid |
| hdr_word | input | HDR_W | Header word (palette entry 0) |
| fetch_start | output | 1 | One-cycle pixel fetch start |
| fetch_base | output | AW | First pixel byte address |
| fetch_fmt | output | 3 | Pixel format code |
| fetch_first | output | SUB_FLD_W | First displayed line |
| fetch_lines | output | DIM_W | Lines to fetch |
| fetch_stride | output | DIM_W+2 | Bytes per line |
| fetch_done | input | 1 | Pixel fetcher finished |
| pal_loaded | output | 1 | First header of this enable period taken |
| sync_err | output | 1 | Buffer overrun, sticky while enabled |
| cond_pulse | output | 3 | Buffer 0 done, buffer 1 done, address fault |
| dma_irq | output | 1 | DMA interrupt strobe |
| active_buf | output | 1 | Index of the buffer used by the next frame |

## Verification
On every cycle, the assertions check the following. A start happens only while enabled and never together with a sync error. It is always paired with exactly one condition bit, the one of the active buffer. Dual mode flips the buffer after a start. The header address always follows the active buffer top. The bench scenarios cover what needs a sequence of frames. These are the depth and offset decoding for each code, the exact fit boundary, and the single palette-loaded pulse per enable period. They also cover the stored header in mode 2, the subpanel line split, and recovery from a sync error or an address fault through a new enable edge.

// File: rtl/lcd_seq_pkg.sv
`timescale 1ns/1ps
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_CHECK = 3'd2,
    ST_START = 3'd3,
    ST_WAIT  = 3'd4
  } seq_state_t;

  typedef enum logic [2:0] {
    FMT_2BPP = 3'd0,
    FMT_4BPP = 3'd1,
    FMT_8BPP = 3'd2,
    FMT_12P  = 3'd3,
    FMT_16A  = 3'd4,
    FMT_NONE = 3'd7
  } pix_fmt_t;

  // bits per pixel for a depth code, 0 for the unsupported code
  function automatic logic [4:0] depth_bits(input logic [2:0] code);
    case (code)
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd0:    return 5'd0;
      default: return 5'd16;
    endcase
  endfunction

  function automatic pix_fmt_t pix_format(input logic [2:0] code, input logic active);
    case (code)
      3'd1:    return FMT_2BPP;
      3'd2:    return FMT_4BPP;
      3'd3:    return FMT_8BPP;
      3'd0:    return FMT_NONE;
      default: return active ? FMT_16A : FMT_12P;
    endcase
  endfunction

  // bytes skipped ahead of the pixel data
  function automatic logic [15:0] data_offset(input logic [2:0] code, input logic has_pal,
                                              input logic [15:0] long_hdr,
                                              input logic [15:0] short_hdr);
    if (!has_pal)       return 16'd0;
    else if (code >= 3) return long_hdr;
    else                return short_hdr;
  endfunction

endpackage

// File: rtl/lcd_hdr_decode.sv
`timescale 1ns/1ps
module lcd_hdr_decode
  import lcd_seq_pkg::*;
#(
  parameter int HDR_W     = 16,
  parameter int CODE_LSB  = 12,
  parameter int OFF_W     = 16,
  parameter int LONG_HDR  = 512,
  parameter int SHORT_HDR = 32
) (
  input  logic [HDR_W-1:0] hdr,
  input  logic             has_pal,
  input  logic             tft,
  output logic             ok,
  output pix_fmt_t         fmt,
  output logic [4:0]       bpp,
  output logic [OFF_W-1:0] offset
);
  localparam logic [15:0] LONG_C  = 16'(LONG_HDR);
  localparam logic [15:0] SHORT_C = 16'(SHORT_HDR);

  logic [2:0] code;
  assign code   = hdr[CODE_LSB+2:CODE_LSB];
  assign bpp    = depth_bits(code);
  assign fmt    = pix_format(code, tft);
  assign ok     = (bpp != 5'd0);
  assign offset = OFF_W'(data_offset(code, has_pal, LONG_C, SHORT_C));
endmodule

// File: rtl/lcd_fit_check.sv
`timescale 1ns/1ps
module lcd_fit_check #(
  parameter int AW    = 32,
  parameter int DIM_W = 11,
  parameter int OFF_W = 16
) (
  input  logic [AW-1:0]    top,
  input  logic [AW-1:0]    bot,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [4:0]       bpp,
  input  logic [OFF_W-1:0] offset,
  output logic             fits,
  output logic [DIM_W+1:0] stride
);
  localparam int PROD_W = 2*DIM_W + 5;
  localparam int NEED_W = PROD_W + 1;
  localparam int SPAN_W = AW + 2;
  localparam int CMP_W  = (NEED_W > SPAN_W) ? NEED_W + 1 : SPAN_W + 1;

  logic [PROD_W-1:0]        bits_total;
  logic [NEED_W-1:0]        need;
  logic signed [SPAN_W-1:0] limit;
  logic [DIM_W+4:0]         line_bits;

  assign bits_total = PROD_W'(width) * PROD_W'(height) * PROD_W'(bpp);
  assign need       = NEED_W'(bits_total >> 3) + NEED_W'(offset);
  assign limit      = $signed({2'b00, bot}) - $signed({2'b00, top}) + SPAN_W'(2);
  assign fits       = !limit[SPAN_W-1] && (CMP_W'(need) <= CMP_W'(limit));

  assign line_bits  = (DIM_W+5)'(width) * (DIM_W+5)'(bpp);
  assign stride     = (DIM_W+2)'(line_bits >> 3);
endmodule

// File: rtl/lcd_line_window.sv
`timescale 1ns/1ps
module lcd_line_window #(
  parameter int DIM_W     = 11,
  parameter int SUB_W     = 32,
  parameter int SUB_FLD_W = 10,
  parameter int FLD_LSB   = 16,
  parameter int ON_BIT    = 31,
  parameter int FIRST_BIT = 29
) (
  input  logic [SUB_W-1:0]     sub,
  input  logic [DIM_W-1:0]     height,
  output logic [SUB_FLD_W-1:0] first,
  output logic [DIM_W-1:0]     lines
);
  logic [SUB_FLD_W-1:0] fld;
  assign fld = sub[FLD_LSB+SUB_FLD_W-1:FLD_LSB];

  always_comb begin
    first = '0;
    lines = height;
    if (sub[ON_BIT]) begin
      if (sub[FIRST_BIT]) first = fld;
      else                lines = DIM_W'(fld);
    end
  end
endmodule

// File: rtl/lcd_frame_seq.sv
`timescale 1ns/1ps
module lcd_frame_seq
  import lcd_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DIM_W     = 11,
  parameter int HDR_W     = 16,
  parameter int SUB_W     = 32,
  parameter int SUB_FLD_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [1:0]           pal_mode,
  input  logic                 tft,
  input  logic                 dual,
  input  logic [1:0]           dma_mask,
  input  logic [DIM_W-1:0]     width,
  input  logic [DIM_W-1:0]     height,
  input  logic [SUB_W-1:0]     subpanel,
  input  logic [AW-1:0]        buf0_top,
  input  logic [AW-1:0]        buf0_bot,
  input  logic [AW-1:0]        buf1_top,
  input  logic [AW-1:0]        buf1_bot,
  input  logic [1:0]           top_ok,
  input  logic [1:0]           bot_ok,
  input  logic                 frame_req,
  output logic                 hdr_req,
  output logic [AW-1:0]        hdr_addr,
  input  logic                 hdr_ack,
  input  logic [HDR_W-1:0]     hdr_word,
  output logic                 fetch_start,
  output logic [AW-1:0]        fetch_base,
  output logic [2:0]           fetch_fmt,
  output logic [SUB_FLD_W-1:0] fetch_first,
  output logic [DIM_W-1:0]     fetch_lines,
  output logic [DIM_W+1:0]     fetch_stride,
  input  logic                 fetch_done,
  output logic                 pal_loaded,
  output logic                 sync_err,
  output logic [2:0]           cond_pulse,
  output logic                 dma_irq,
  output logic                 active_buf
);
  localparam int OFF_W    = 16;
  localparam int STRIDE_W = DIM_W + 2;

  seq_state_t state_q;
  logic en_q, run_q, cur_q, pal_seen_q, sync_q, fault_q, pal_evt_q;
  logic [HDR_W-1:0] hdr_q;

  logic [AW-1:0] cur_top, cur_bot;
  logic          en_rise, bufs_ok, has_pal;

  // decoded and derived frame parameters, named for the assertions
  logic             dec_ok, fits;
  pix_fmt_t         dec_fmt;
  logic [4:0]       dec_bpp;
  logic [OFF_W-1:0] dec_off;
  logic [STRIDE_W-1:0]  calc_stride;
  logic [SUB_FLD_W-1:0] win_first;
  logic [DIM_W-1:0]     win_lines;
  logic start_evt, overrun_evt;

  logic [AW-1:0]        base_q;
  pix_fmt_t             fmt_q;
  logic [SUB_FLD_W-1:0] first_q;
  logic [DIM_W-1:0]     lines_q;
  logic [STRIDE_W-1:0]  stride_q;

  assign cur_top = cur_q ? buf1_top : buf0_top;
  assign cur_bot = cur_q ? buf1_bot : buf0_bot;
  assign en_rise = enable && !en_q;
  assign bufs_ok = top_ok[0] && bot_ok[0] && (!dual || (top_ok[1] && bot_ok[1]));
  assign has_pal = (pal_mode != 2'd2);

  lcd_hdr_decode #(.HDR_W(HDR_W), .OFF_W(OFF_W)) u_dec (
    .hdr(hdr_q), .has_pal(has_pal), .tft(tft),
    .ok(dec_ok), .fmt(dec_fmt), .bpp(dec_bpp), .offset(dec_off)
  );

  lcd_fit_check #(.AW(AW), .DIM_W(DIM_W), .OFF_W(OFF_W)) u_fit (
    .top(cur_top), .bot(cur_bot), .width(width), .height(height),
    .bpp(dec_bpp), .offset(dec_off), .fits(fits), .stride(calc_stride)
  );

  lcd_line_window #(.DIM_W(DIM_W), .SUB_W(SUB_W), .SUB_FLD_W(SUB_FLD_W)) u_win (
    .sub(subpanel), .height(height), .first(win_first), .lines(win_lines)
  );

  assign start_evt   = (state_q == ST_START);
  assign overrun_evt = (state_q == ST_CHECK) && dec_ok && !fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      en_q       <= 1'b0;
      run_q      <= 1'b0;
      cur_q      <= 1'b0;
      pal_seen_q <= 1'b0;
      sync_q     <= 1'b0;
      fault_q    <= 1'b0;
      pal_evt_q  <= 1'b0;
      hdr_q      <= '0;
      base_q     <= '0;
      fmt_q      <= FMT_2BPP;
      first_q    <= '0;
      lines_q    <= '0;
      stride_q   <= '0;
    end else begin
      en_q      <= enable;
      fault_q   <= 1'b0;
      pal_evt_q <= 1'b0;
      if (!enable) begin
        state_q <= ST_IDLE;
        run_q   <= 1'b0;
        sync_q  <= 1'b0;
      end else if (en_rise) begin
        state_q    <= ST_IDLE;
        cur_q      <= 1'b0;
        pal_seen_q <= 1'b0;
        sync_q     <= 1'b0;
        run_q      <= bufs_ok;
        fault_q    <= !bufs_ok;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (run_q && frame_req && pal_mode != 2'd1)
              state_q <= has_pal ? ST_HDR : ST_CHECK;
          end
          ST_HDR: begin
            if (hdr_ack) begin
              hdr_q      <= hdr_word;
              pal_seen_q <= 1'b1;
              pal_evt_q  <= !pal_seen_q;
              state_q    <= ST_CHECK;
            end
          end
          ST_CHECK: begin
            if (!dec_ok) begin
              state_q <= ST_IDLE;
            end else if (!fits) begin
              sync_q  <= 1'b1;
              run_q   <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              base_q   <= cur_top + AW'(dec_off);
              fmt_q    <= dec_fmt;
              first_q  <= win_first;
              lines_q  <= win_lines;
              stride_q <= calc_stride;
              state_q  <= ST_START;
            end
          end
          ST_START: begin
            if (dual) cur_q <= ~cur_q;
            state_q <= ST_WAIT;
          end
          ST_WAIT: begin
            if (fetch_done) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign hdr_req      = (state_q == ST_HDR);
  assign hdr_addr     = cur_top;
  assign fetch_start  = start_evt;
  assign fetch_base   = base_q;
  assign fetch_fmt    = fmt_q;
  assign fetch_first  = first_q;
  assign fetch_lines  = lines_q;
  assign fetch_stride = stride_q;
  assign pal_loaded   = pal_evt_q;
  assign sync_err     = sync_q;
  assign active_buf   = cur_q;
  assign cond_pulse   = {fault_q, start_evt && cur_q, start_evt && !cur_q};
  assign dma_irq      = (start_evt && dma_mask[0]) || (fault_q && dma_mask[1]);

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> enable); // R2
  AST_HDR_AT_ACTIVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_req |-> hdr_addr == (active_buf ? buf1_top : buf0_top)); // R3
  AST_NO_START_ON_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> !fetch_start && sync_err); // R6
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !fetch_start && !hdr_req); // R6
  AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_pulse)); // R8
  AST_START_MARKS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> cond_pulse[active_buf]); // R8
  AST_DUAL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && dual && enable) |=> active_buf != $past(active_buf)); // R9
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_start && !dual) |=> $stable(active_buf)); // R9
endmodule

// File: tb/test_lcd_frame_seq.sv
`timescale 1ns/1ps
module test_lcd_frame_seq;
  localparam int AW = 32, DIM_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, tft = 0, dual = 0, frame_req = 0;
  logic [1:0] pal_mode = 0, dma_mask = 2'b11, top_ok = 2'b11, bot_ok = 2'b11;
  logic [DIM_W-1:0] width = 16, height = 8;
  logic [31:0] subpanel = 0;
  logic [AW-1:0] b0t = 32'h1000, b0b = 32'h2000, b1t = 32'h8000, b1b = 32'h9000;
  logic hdr_req, hdr_ack = 0, fetch_start, fetch_done = 0, pal_loaded, sync_err, dma_irq, active_buf;
  logic [AW-1:0] hdr_addr, fetch_base;
  logic [15:0] hdr_word = 0;
  logic [2:0] fetch_fmt, cond_pulse;
  logic [9:0] fetch_first;
  logic [DIM_W-1:0] fetch_lines;
  logic [DIM_W+1:0] fetch_stride;

  always #10 clk = ~clk;

  lcd_frame_seq i_lcd_frame_seq (
    .clk, .rst_n, .enable, .pal_mode, .tft, .dual, .dma_mask, .width, .height,
    .subpanel, .buf0_top(b0t), .buf0_bot(b0b), .buf1_top(b1t), .buf1_bot(b1b),
    .top_ok, .bot_ok, .frame_req, .hdr_req, .hdr_addr, .hdr_ack, .hdr_word,
    .fetch_start, .fetch_base, .fetch_fmt, .fetch_first, .fetch_lines,
    .fetch_stride, .fetch_done, .pal_loaded, .sync_err, .cond_pulse, .dma_irq,
    .active_buf
  );

  int n_chk = 0, n_err = 0;
  int n_start = 0, n_c0 = 0, n_c1 = 0, n_c2 = 0, n_dma = 0, n_pal = 0, n_hdr = 0;
  logic [15:0] tb_hdr = 0;
  logic prev_start = 0, finished = 0;
  logic [AW-1:0] seen_hdr_addr = 0;
  logic [AW-1:0] cap_base; logic [2:0] cap_fmt; logic [9:0] cap_first;
  logic [DIM_W-1:0] cap_lines; logic [DIM_W+1:0] cap_stride;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // fetcher and memory stand-ins plus event counters, all away from the active edge
  always @(negedge clk) begin
    fetch_done = prev_start;
    prev_start = fetch_start;
    if (hdr_req && !hdr_ack) begin
      hdr_ack = 1; hdr_word = tb_hdr; n_hdr++; seen_hdr_addr = hdr_addr;
    end else hdr_ack = 0;
    if (fetch_start) begin
      n_start++;
      cap_base = fetch_base; cap_fmt = fetch_fmt; cap_first = fetch_first;
      cap_lines = fetch_lines; cap_stride = fetch_stride;
    end
    if (cond_pulse[0]) n_c0++;
    if (cond_pulse[1]) n_c1++;
    if (cond_pulse[2]) n_c2++;
    if (dma_irq) n_dma++;
    if (pal_loaded) n_pal++;
  end

  // reference arithmetic, integer form
  function automatic int ref_bpp(input int code);
    if (code == 0) return 0;
    if (code <= 3) return 1 << code;
    return 16;
  endfunction
  function automatic int ref_fmt(input int code, input logic t);
    if (code >= 4) return t ? 4 : 3;
    return code - 1;
  endfunction
  function automatic int ref_off(input int code, input logic pal);
    if (!pal) return 0;
    return (code >= 3) ? 512 : 32;
  endfunction

  task automatic do_frame(input int code);
    tb_hdr = 16'(code << 12) | 16'h0a5;
    @(negedge clk); frame_req = 1;
    @(negedge clk); frame_req = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_enable;
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_frame(input string tag, input int code, input logic [AW-1:0] top);
    chk({tag, " base"}, cap_base, 64'(top + ref_off(code, pal_mode != 2)));
    chk({tag, " fmt"}, cap_fmt, 64'(ref_fmt(code, tft)));
    chk({tag, " stride"}, cap_stride, 64'(width * ref_bpp(code) / 8));
  endtask

  int s;
  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fetch_start", fetch_start, 0); chk("R1 hdr_req", hdr_req, 0);
    chk("R1 sync_err", sync_err, 0); chk("R1 cond", cond_pulse, 0);
    chk("R1 dma_irq", dma_irq, 0); chk("R1 active_buf", active_buf, 0);
    rst_n = 1;
    @(negedge clk); enable = 1; repeat (2) @(negedge clk);

    // R3 R4 R5 R8: 8 bpp with long header
    do_frame(3);
    chk("R8 start count", n_start, 1); chk("R8 cond0", n_c0, 1); chk("R8 dma", n_dma, 1);
    chk("R3 hdr addr", seen_hdr_addr, b0t); chk("R3 pal once", n_pal, 1);
    expect_frame("R5 code3", 3, b0t);
    chk("R11 default lines", cap_lines, height); chk("R11 default first", cap_first, 0);
    // R4 R5: 2 bpp short header; second header gives no palette event
    do_frame(1); expect_frame("R4 code1", 1, b0t); chk("R3 pal still once", n_pal, 1);
    do_frame(2); expect_frame("R4 code2", 2, b0t);
    tft = 0; do_frame(5); expect_frame("R4 code5 passive", 5, b0t);
    tft = 1; do_frame(7); expect_frame("R4 code7 active", 7, b0t);
    chk("R9 single holds", active_buf, 0);
    // R4 code 0 dropped
    s = n_start; do_frame(0);
    chk("R4 code0 no start", n_start, s); chk("R4 code0 no error", sync_err, 0);
    // R8 mask bit 0 clear
    dma_mask = 2'b10; s = n_dma; do_frame(3); chk("R8 masked dma", n_dma, s);
    dma_mask = 2'b11;
    // R11 subpanel split
    subpanel = 32'hA000_0000 | (32'd5 << 16); do_frame(3);
    chk("R11 first", cap_first, 5); chk("R11 lines full", cap_lines, height);
    subpanel = 32'h8000_0000 | (32'd3 << 16); do_frame(3);
    chk("R11 first zero", cap_first, 0); chk("R11 lines field", cap_lines, 3);
    subpanel = 0;
    // R3 mode 2: no header read, stored code 3, offset 0
    pal_mode = 2; s = n_hdr; do_frame(1);
    chk("R3 mode2 no hdr", n_hdr, s); expect_frame("R3 mode2", 3, b0t);
    // R2 mode 1 ignored
    pal_mode = 1; s = n_start; do_frame(3);
    chk("R2 mode1 no start", n_start, s); chk("R2 mode1 no hdr", n_hdr, s == 0 ? 0 : n_hdr);
    pal_mode = 0;
    // R6 exact limit accepted: need 512+128 = 640 = span+2
    b0b = b0t + 638; s = n_start; do_frame(3); chk("R6 exact fit", n_start, s + 1);
    chk("R6 no err at limit", sync_err, 0);
    b0b = b0t + 637; do_frame(3);
    chk("R6 overrun no start", n_start, s + 1); chk("R6 sync_err set", sync_err, 1);
    s = n_hdr; do_frame(3); chk("R6 stopped", n_hdr, s);
    // R7 disable clears
    @(negedge clk); enable = 0; repeat (2) @(negedge clk);
    chk("R7 sync clear", sync_err, 0);
    b0b = 32'h2000; enable = 1; repeat (2) @(negedge clk);
    s = n_pal; do_frame(3); chk("R3 pal per enable", n_pal, s + 1);
    // R9 dual alternation
    dual = 1; pulse_enable;
    s = n_c1; do_frame(3); chk("R9 first buf0 base", cap_base, b0t + 512);
    chk("R9 toggled", active_buf, 1);
    do_frame(3); chk("R9 buf1 base", cap_base, b1t + 512); chk("R8 cond1", n_c1, s + 1);
    chk("R3 hdr buf1", seen_hdr_addr, b1t); chk("R9 back", active_buf, 0);
    // R7 enable edge resets active buffer
    do_frame(3); pulse_enable; chk("R7 buf reset", active_buf, 0);
    // R10 address fault in dual mode
    bot_ok = 2'b01; s = n_c2; pulse_enable;
    chk("R10 fault cond", n_c2, s + 1);
    s = n_start; do_frame(3); chk("R10 no frames", n_start, s);
    // R10 buffer 1 not checked without dual
    dual = 0; s = n_c2; pulse_enable; chk("R10 single ok", n_c2, s);
    s = n_start; do_frame(3); chk("R10 runs", n_start, s + 1);
    // R10 mask bit 1 clear
    dma_mask = 2'b01; dual = 1; s = n_dma; pulse_enable; chk("R10 masked dma", n_dma, s);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule